// File: doc/BRIEF.md
# PAM4 Periodic Test Sequence Generator

This block emits fixed, periodic four-level test sequences as 2-bit symbol values, one symbol per clock, for driving a transmitter path during compliance and characterisation work. A 2-bit mode input chooses one of four sequences:
- a clock-like alternation of the two outer levels
- a 62-symbol pattern that stresses even/odd jitter
- a 16-symbol square wave
- a 160-symbol staircase used to measure transmitter level linearity

Each symbol is a level number from 0 (lowest) to 3 (highest), written as a plain binary value. The block is built from position counters and a small combinational symbol map, not from a PRBS engine or pattern memory.

The outputs are registered. A valid flag qualifies every symbol, and a start marker flags the first symbol of each period. Dropping enable parks the block: the symbol goes to 0 and valid goes low. A change of mode while enabled restarts the newly chosen sequence from its first symbol.

Top module: `pam4_test_seq_gen`

## Requirements
- R1: While reset is active and in the cycles after it until enable is first sampled high, `sym_out` is 0, `sym_valid` is 0 and `period_start` is 0.
- R2: When `enable` is sampled low at a rising edge, the outputs after that edge are `sym_out`=0, `sym_valid`=0 and `period_start`=0.
- R3: When `enable` is sampled high at an edge after being low, the outputs after that edge carry symbol index 0 of the selected sequence, with `sym_valid`=1 and `period_start`=1. Outputs lag the sampled inputs by exactly one clock.
- R4: Mode 2'b00 outputs levels 0,3,0,3,... with a period of 2.
- R5: Mode 2'b01 has a period of 62. Indices 0..29 alternate 0,3 (fifteen pairs), and indices 30..61 alternate 3,0 (sixteen pairs).
- R6: Mode 2'b10 outputs eight symbols of level 3 followed by eight of level 0, with a period of 16.
- R7: Mode 2'b11 outputs each level of the list 0,1,2,3,0,3,0,3,2,1 for 16 consecutive symbols, with a period of 160.
- R8: `period_start` is 1 exactly on symbol index 0 of each period while valid, and 0 on every other symbol.
- R9: If the sampled `mode` differs from its value at the previous edge while enable is high, the next output is index 0 of the new sequence, with `period_start`=1.
- R10: After enable is dropped and raised again, the sequence restarts at index 0 even if the mode did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; low parks it |
| mode | input | 2 | Sequence select: 0 clock-like, 1 even/odd, 2 square, 3 linearity |
| sym_out | output | 2 | PAM4 level number 0..3 |
| sym_valid | output | 1 | Symbol qualifier |
| period_start | output | 1 | High on the first symbol of each period |

## Verification
Several properties are checked on every cycle:
- the idle outputs after enable falls
- the start marker being qualified by valid
- the first-symbol value of each sequence
- the strict alternation in the clock-like mode
- the square wave only stepping down mid-period
- the restart after a mode change
- the position counter staying inside the current period

The exact period lengths are shown only by the bench scenarios, which run several full periods of each sequence against an independent reference model. The same applies to the even/odd phase flip at index 30, the linearity staircase order, and restarts after a re-enable with the same mode.

// File: rtl/pam4_seq_pkg.sv
package pam4_seq_pkg;

    typedef enum logic [1:0] {
        PAT_CLK     = 2'd0,
        PAT_EVENODD = 2'd1,
        PAT_SQUARE  = 2'd2,
        PAT_LINEAR  = 2'd3
    } pat_mode_e;

    typedef logic [1:0] sym_t;

    // Registered output bundle of the top level
    typedef struct packed {
        pat_mode_e mode;
        sym_t      sym;
        logic      vld;
        logic      sop;
    } out_s;

    localparam int NUM_LIN_STEPS = 10;

    // Level staircase used by the linearity sequence
    function automatic sym_t lin_level(input int step);
        sym_t lvl;
        case (step)
            0: lvl = 2'd0;
            1: lvl = 2'd1;
            2: lvl = 2'd2;
            3: lvl = 2'd3;
            4: lvl = 2'd0;
            5: lvl = 2'd3;
            6: lvl = 2'd0;
            7: lvl = 2'd3;
            8: lvl = 2'd2;
            9: lvl = 2'd1;
            default: lvl = 2'd0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/pam4_seq_pos.sv
module pam4_seq_pos
    import pam4_seq_pkg::*;
#(
    parameter int LEN_CLK = 2,
    parameter int LEN_EO  = 62,
    parameter int LEN_SQ  = 16,
    parameter int LEN_LIN = 160,
    parameter int POS_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  pat_mode_e        mode,
    output logic [POS_W-1:0] cur_idx,
    output logic             restart
);

    typedef struct packed {
        pat_mode_e        mode;
        logic [POS_W-1:0] pos;
    } pos_s;

    pos_s st_d, st_q;

    function automatic logic [POS_W-1:0] last_idx(input pat_mode_e m);
        case (m)
            PAT_CLK:     return POS_W'(LEN_CLK - 1);
            PAT_EVENODD: return POS_W'(LEN_EO - 1);
            PAT_SQUARE:  return POS_W'(LEN_SQ - 1);
            default:     return POS_W'(LEN_LIN - 1);
        endcase
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode;
        restart   = !enable || (mode != st_q.mode);
        cur_idx   = restart ? '0 : st_q.pos;
        if (!enable) begin
            st_d.pos = '0;
        end else if (cur_idx == last_idx(mode)) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = cur_idx + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PAT_CLK, pos: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R5 R6 R7
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= last_idx(st_q.mode));

    // R10
    idle_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.pos == '0));

endmodule

// File: rtl/pam4_seq_map.sv
module pam4_seq_map
    import pam4_seq_pkg::*;
#(
    parameter int SQ_HALF   = 8,
    parameter int LIN_HOLD  = 16,
    parameter int EO_PAIRS1 = 15,
    parameter int POS_W     = 8
) (
    input  pat_mode_e        mode,
    input  logic [POS_W-1:0] idx,
    output sym_t             sym
);

    localparam int EO_SPLIT = 2 * EO_PAIRS1;

    sym_t sym_clk, sym_eo, sym_sq, sym_lin;
    logic odd;

    always_comb begin
        odd     = idx[0];
        sym_clk = odd ? 2'd3 : 2'd0;
        if (int'(idx) < EO_SPLIT) begin
            sym_eo = odd ? 2'd3 : 2'd0;
        end else begin
            sym_eo = odd ? 2'd0 : 2'd3;
        end
        sym_sq  = (int'(idx) < SQ_HALF) ? 2'd3 : 2'd0;
        sym_lin = lin_level(int'(idx) / LIN_HOLD);
        case (mode)
            PAT_CLK:     sym = sym_clk;
            PAT_EVENODD: sym = sym_eo;
            PAT_SQUARE:  sym = sym_sq;
            default:     sym = sym_lin;
        endcase
    end

endmodule

// File: rtl/pam4_test_seq_gen.sv
module pam4_test_seq_gen
    import pam4_seq_pkg::*;
#(
    parameter int SQ_HALF   = 8,
    parameter int LIN_HOLD  = 16,
    parameter int EO_PAIRS1 = 15,
    parameter int EO_PAIRS2 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode,
    output logic [1:0] sym_out,
    output logic       sym_valid,
    output logic       period_start
);

    localparam int LEN_CLK = 2;
    localparam int LEN_EO  = 2 * (EO_PAIRS1 + EO_PAIRS2);
    localparam int LEN_SQ  = 2 * SQ_HALF;
    localparam int LEN_LIN = NUM_LIN_STEPS * LIN_HOLD;
    localparam int MAX_A   = (LEN_EO > LEN_SQ) ? LEN_EO : LEN_SQ;
    localparam int MAX_B   = (LEN_LIN > LEN_CLK) ? LEN_LIN : LEN_CLK;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int POS_W   = $clog2(MAX_LEN);

    pat_mode_e        mode_e;
    logic [POS_W-1:0] cur_idx;
    logic             restart;
    sym_t             map_sym;
    out_s             out_d, out_q;

    assign mode_e = pat_mode_e'(mode);

    pam4_seq_pos #(
        .LEN_CLK (LEN_CLK),
        .LEN_EO  (LEN_EO),
        .LEN_SQ  (LEN_SQ),
        .LEN_LIN (LEN_LIN),
        .POS_W   (POS_W)
    ) i_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode_e),
        .cur_idx (cur_idx),
        .restart (restart)
    );

    pam4_seq_map #(
        .SQ_HALF   (SQ_HALF),
        .LIN_HOLD  (LIN_HOLD),
        .EO_PAIRS1 (EO_PAIRS1),
        .POS_W     (POS_W)
    ) i_map (
        .mode (mode_e),
        .idx  (cur_idx),
        .sym  (map_sym)
    );

    always_comb begin
        out_d      = out_q;
        out_d.mode = mode_e;
        if (enable) begin
            out_d.sym = map_sym;
            out_d.vld = 1'b1;
            out_d.sop = restart || (cur_idx == '0);
        end else begin
            out_d.sym = 2'd0;
            out_d.vld = 1'b0;
            out_d.sop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{mode: PAT_CLK, sym: 2'd0, vld: 1'b0, sop: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign sym_out      = out_q.sym;
    assign sym_valid    = out_q.vld;
    assign period_start = out_q.sop;

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sym_valid && sym_out == 2'd0 && !period_start));

    // R8
    start_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> sym_valid);

    // R3
    first_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (sym_out == ((out_q.mode == PAT_SQUARE) ? 2'd3 : 2'd0)));

    // R4
    clk_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && $past(sym_valid) && out_q.mode == PAT_CLK &&
         $past(out_q.mode) == PAT_CLK && !period_start) |-> (sym_out != $past(sym_out)));

    // R6
    square_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && $past(sym_valid) && out_q.mode == PAT_SQUARE &&
         $past(out_q.mode) == PAT_SQUARE && !period_start &&
         sym_out != $past(sym_out)) |-> (sym_out == 2'd0));

    // R9
    restart_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(rst_n) && mode != $past(mode)) |=> period_start);

endmodule

// File: tb/test_pam4_test_seq_gen.sv
`timescale 1ns/1ps
module test_pam4_test_seq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] sym_out;
    logic       sym_valid;
    logic       period_start;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pam4_test_seq_gen i_pam4_test_seq_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .mode         (mode),
        .sym_out      (sym_out),
        .sym_valid    (sym_valid),
        .period_start (period_start)
    );

    // Stimulus segments: {enable, mode[1:0], cycles[8:0]}
    localparam int NSEG = 12;
    localparam logic [11:0] SEGS [NSEG] = '{
        {1'b1, 2'd0, 9'd10},
        {1'b1, 2'd1, 9'd130},
        {1'b1, 2'd2, 9'd40},
        {1'b1, 2'd3, 9'd330},
        {1'b0, 2'd3, 9'd3},
        {1'b1, 2'd3, 9'd20},
        {1'b1, 2'd2, 9'd5},
        {1'b1, 2'd1, 9'd70},
        {1'b1, 2'd0, 9'd3},
        {1'b0, 2'd0, 9'd2},
        {1'b1, 2'd2, 9'd17},
        {1'b1, 2'd1, 9'd33}
    };

    // Reference model state: expected outputs after the next edge
    logic       m_valid = 1'b0;
    logic       m_start = 1'b0;
    logic [1:0] m_sym = 2'd0;
    int         m_idx = 0;
    logic [1:0] last_md = 2'd0;
    logic       last_en = 1'b0;
    logic [1:0] m_mode = 2'd0;
    string      tag_hint = "";

    function automatic int plen(input logic [1:0] md);
        case (md)
            2'd0: return 2;
            2'd1: return 62;
            2'd2: return 16;
            default: return 160;
        endcase
    endfunction

    function automatic logic [1:0] ref_sym(input logic [1:0] md, input int idx);
        int steps [10] = '{0, 1, 2, 3, 0, 3, 0, 3, 2, 1};
        case (md)
            2'd0: return (idx % 2 == 1) ? 2'd3 : 2'd0;
            2'd1: begin
                if (idx < 30) return (idx % 2 == 1) ? 2'd3 : 2'd0;
                else          return (idx % 2 == 1) ? 2'd0 : 2'd3;
            end
            2'd2: return (idx < 8) ? 2'd3 : 2'd0;
            default: return 2'(steps[idx / 16]);
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual={vld,sop,sym}=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic string auto_tag();
        if (!m_valid) return "R2";
        if (m_start)  return "R8";
        case (m_mode)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Check outputs produced by the previous edge, then drive new inputs
    task automatic apply(input logic en, input logic [1:0] md);
        int idx;
        @(negedge clk);
        check((tag_hint != "") ? tag_hint : auto_tag(),
              {sym_valid, period_start, sym_out}, {m_valid, m_start, m_sym});
        tag_hint = "";
        enable = en;
        mode   = md;
        if (!en) begin
            m_valid = 1'b0; m_start = 1'b0; m_sym = 2'd0; m_idx = 0;
        end else begin
            if (md != last_md || !last_en) idx = 0;
            else idx = (m_idx + 1 == plen(md)) ? 0 : m_idx + 1;
            m_valid = 1'b1;
            m_start = (idx == 0);
            m_sym   = ref_sym(md, idx);
            m_idx   = idx;
        end
        m_mode  = md;
        last_md = md;
        last_en = en;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle during and after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {sym_valid, period_start, sym_out}, 4'b0000);
        rst_n = 1'b1;
        apply(1'b0, 2'd3);
        tag_hint = "R1";
        apply(1'b0, 2'd2);

        // Table walk
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < int'(SEGS[s][8:0]); c++) begin
                apply(SEGS[s][11], SEGS[s][10:9]);
            end
        end

        // R10: re-enable with the same mode restarts at index 0
        apply(1'b1, 2'd0);
        apply(1'b0, 2'd0);
        apply(1'b1, 2'd0);
        tag_hint = "R10";
        apply(1'b1, 2'd0);

        // R3: first symbol after enable, square mode (level 3, start)
        apply(1'b0, 2'd2);
        apply(1'b1, 2'd2);
        tag_hint = "R3";
        apply(1'b1, 2'd2);

        // R9: change mode mid-period of the linearity sequence
        for (int c = 0; c < 40; c++) apply(1'b1, 2'd3);
        apply(1'b1, 2'd1);
        tag_hint = "R9";
        apply(1'b1, 2'd1);

        // R5: boundary at index 30 of the even/odd sequence
        for (int c = 0; c < 70; c++) apply(1'b1, 2'd1);

        // R7: full staircase through the wrap
        for (int c = 0; c < 170; c++) apply(1'b1, 2'd3);

        apply(1'b0, 2'd0);
        apply(1'b0, 2'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule